// File: doc/BRIEF.md
# Sleep Entry and Wakeup Controller

This block decides when a small processor core stops its clock and when it starts it again. The core sends one-cycle strobes when it executes a wait-for-interrupt or a wait-for-event instruction. It sends a third strobe when it returns from its lowest-priority interrupt handler. Two control bits change the rules. One puts the core back to sleep on that handler return. The other lets an interrupt that is pending but not enabled count as an event. From these inputs the block derives a sleep flag and a gated core clock enable. It also produces a one-cycle wake pulse that carries a cause code.

The block qualifies wakeup against the per-line interrupt pending and enable vectors and a set of external event lines. Which of these conditions may wake the core depends on how sleep was entered. A one-bit event latch remembers an event that arrives while it is not consumed. The next wait-for-event then returns at once instead of sleeping.

A separate enable register holds the per-peripheral clock enables, and software writes it at any time. Entering or leaving sleep never changes these enables or any other output except the sleep flag, the core clock enable and the wake pulse. All pins are plain control and status signals: there is no data stream, so no valid/ready handshake and no back-pressure.

Top module: `lps_sleep_ctrl`

## Requirements
- R1: After reset, `asleep_o`=0, `core_clk_en_o`=1, `wake_o`=0, `wake_cause_o`=0, and `pclk_en_o` equals the parameter `PCLK_RST`. The default for `PCLK_RST` is 8'h03, which enables the two memory interface clocks in bits 0 and 1.
- R2: While awake, a `wfi_i` or `wfe_i` strobe with no wake condition present puts the block to sleep. From the cycle after the sampling edge, `asleep_o`=1 and `core_clk_en_o`=0. Strobes that arrive while asleep are ignored.
- R3: When `sleep_on_exit_i`=1, an `isr_ret_i` strobe enters sleep with the wait-for-interrupt wake rules. When `sleep_on_exit_i`=0, `isr_ret_i` has no effect.
- R4: A sleep entered with wait-for-interrupt ends only when some line has both `irq_pend_i` and `irq_en_i` set. External events and pending lines that are not enabled leave it asleep.
- R5: A sleep entered with wait-for-event ends on any of three conditions: any `evt_line_i` bit, any enabled pending line, or a pending line that is not enabled while `sev_on_pend_i`=1. A pending line that is not enabled, with `sev_on_pend_i`=0, leaves it asleep.
- R6: A wake condition sampled at an edge clears `asleep_o` and raises `core_clk_en_o` from the next cycle. In that same cycle only, `wake_o`=1 and `wake_cause_o` gives the cause: 1 for an enabled interrupt, 2 for an external event, 3 for a pending line that is not enabled. When several causes are present, the order is 1, then 2, then 3. While `wake_o`=0, `wake_cause_o`=0.
- R7: An event that is not consumed sets the event latch. An event here is any `evt_line_i` bit, or a pending line that is not enabled while `sev_on_pend_i`=1. The next wait-for-event clears the latch and stays awake, and a further wait-for-event then sleeps.
- R8: If a wake condition of the requested kind is present in the cycle of the request, the block stays awake. For wait-for-event, a set event latch also counts. An event that coincides with a wait-for-event request is consumed and does not set the latch.
- R9: A `pclk_wr_i` strobe loads `pclk_wdata_i` into `pclk_en_o`. Otherwise `pclk_en_o` holds its value, including across sleep entry and wakeup.
- R10: If `wfi_i` and `wfe_i` arrive in the same cycle, the wait-for-interrupt rules apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfi_i | input | 1 | Wait-for-interrupt executed strobe |
| wfe_i | input | 1 | Wait-for-event executed strobe |
| isr_ret_i | input | 1 | Return from lowest-priority handler strobe |
| sleep_on_exit_i | input | 1 | Sleep again on handler return |
| sev_on_pend_i | input | 1 | Pending but not enabled lines count as events |
| irq_pend_i | input | N_IRQ | Interrupt pending per line |
| irq_en_i | input | N_IRQ | Interrupt enable per line |
| evt_line_i | input | N_EVT | External event lines |
| pclk_wr_i | input | 1 | Peripheral enable write strobe |
| pclk_wdata_i | input | N_PCLK | Peripheral enable write value |
| asleep_o | output | 1 | Core is asleep |
| core_clk_en_o | output | 1 | Core clock enable |
| pclk_en_o | output | N_PCLK | Per-peripheral clock enables |
| wake_o | output | 1 | One-cycle wakeup pulse |
| wake_cause_o | output | 2 | Wake cause code |

## Verification
Sleep is entered in three ways: a wait-for-interrupt strobe, a wait-for-event strobe, and a handler return under sleep-on-exit. While asleep, the bench offers an external event, a pending line that is not enabled with and without the send-event bit, and an enabled interrupt. This separates the two wake rule sets. A wake condition that arrives together with the request, and two requests in one cycle, show which rule set applies at entry. Events that are left unconsumed, followed by repeated wait-for-event strobes, show the latch being set and cleared. Simultaneous causes check the cause priority, and writes to the enable register around sleep show that it holds its value.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_IRQ  = 2'd1,
    CAUSE_EVT  = 2'd2,
    CAUSE_PEND = 2'd3
  } wake_cause_t;

  typedef enum logic {
    MODE_WFI = 1'b0,
    MODE_WFE = 1'b1
  } sleep_mode_t;
endpackage

// File: rtl/lps_wake_qual.sv
module lps_wake_qual #(
  parameter int N_IRQ = 8,
  parameter int N_EVT = 4
) (
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_IRQ-1:0] irq_en_i,
  input  logic [N_EVT-1:0] evt_line_i,
  input  logic             sev_on_pend_i,
  output logic             irq_hit_o,
  output logic             ext_hit_o,
  output logic             pend_hit_o
);
  logic [N_IRQ-1:0] accepted;
  logic [N_IRQ-1:0] masked_pend;

  // per-line split of pending lines into accepted and masked
  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign accepted[i]    = irq_pend_i[i] & irq_en_i[i];
    assign masked_pend[i] = irq_pend_i[i] & ~irq_en_i[i];
  end

  assign irq_hit_o  = |accepted;
  assign ext_hit_o  = |evt_line_i;
  assign pend_hit_o = sev_on_pend_i & (|masked_pend);
endmodule

// File: rtl/lps_event_latch.sv
module lps_event_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (clr_i) q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
  end
endmodule

// File: rtl/lps_pclk_reg.sv
module lps_pclk_reg #(
  parameter int               N_PCLK   = 8,
  parameter logic [N_PCLK-1:0] PCLK_RST = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [N_PCLK-1:0] wdata_i,
  output logic [N_PCLK-1:0] en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_o <= PCLK_RST;
    else if (wr_i) en_o <= wdata_i;
  end
endmodule

// File: rtl/lps_sleep_ctrl.sv
module lps_sleep_ctrl
  import lps_pkg::*;
#(
  parameter int               N_IRQ    = 8,
  parameter int               N_EVT    = 4,
  parameter int               N_PCLK   = 8,
  parameter logic [N_PCLK-1:0] PCLK_RST = 8'h03
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfi_i,
  input  logic              wfe_i,
  input  logic              isr_ret_i,
  input  logic              sleep_on_exit_i,
  input  logic              sev_on_pend_i,
  input  logic [N_IRQ-1:0]  irq_pend_i,
  input  logic [N_IRQ-1:0]  irq_en_i,
  input  logic [N_EVT-1:0]  evt_line_i,
  input  logic              pclk_wr_i,
  input  logic [N_PCLK-1:0] pclk_wdata_i,
  output logic              asleep_o,
  output logic              core_clk_en_o,
  output logic [N_PCLK-1:0] pclk_en_o,
  output logic              wake_o,
  output logic [1:0]        wake_cause_o
);
  logic        irq_hit, ext_hit, pend_hit, ev_now;
  logic        req_wfi, req_wfe;
  logic        asleep_q, asleep_d;
  sleep_mode_t mode_q, mode_d;
  logic        wake_cond, wake_d;
  wake_cause_t cause_d, cause_q;
  logic        latch_q, latch_clr;

  lps_wake_qual #(.N_IRQ(N_IRQ), .N_EVT(N_EVT)) u_qual (
    .irq_pend_i   (irq_pend_i),
    .irq_en_i     (irq_en_i),
    .evt_line_i   (evt_line_i),
    .sev_on_pend_i(sev_on_pend_i),
    .irq_hit_o    (irq_hit),
    .ext_hit_o    (ext_hit),
    .pend_hit_o   (pend_hit)
  );

  assign ev_now  = ext_hit | pend_hit;
  assign req_wfi = wfi_i | (isr_ret_i & sleep_on_exit_i);
  assign req_wfe = wfe_i & ~req_wfi;

  // wake condition while asleep depends on how sleep was entered
  always_comb begin
    if (mode_q == MODE_WFE) wake_cond = irq_hit | ev_now;
    else                    wake_cond = irq_hit;
  end

  always_comb begin
    if (irq_hit)      cause_d = CAUSE_IRQ;
    else if (ext_hit) cause_d = CAUSE_EVT;
    else              cause_d = CAUSE_PEND;
  end

  // entry and exit decision
  always_comb begin
    asleep_d = asleep_q;
    mode_d   = mode_q;
    wake_d   = 1'b0;
    if (!asleep_q) begin
      if (req_wfi) begin
        if (!irq_hit) begin
          asleep_d = 1'b1;
          mode_d   = MODE_WFI;
        end
      end else if (req_wfe) begin
        if (!(latch_q | ev_now | irq_hit)) begin
          asleep_d = 1'b1;
          mode_d   = MODE_WFE;
        end
      end
    end else if (wake_cond) begin
      asleep_d = 1'b0;
      wake_d   = 1'b1;
    end
  end

  assign latch_clr = (!asleep_q & req_wfe) |
                     (asleep_q & (mode_q == MODE_WFE) & wake_cond);

  lps_event_latch u_latch (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(ev_now),
    .clr_i(latch_clr),
    .q_o  (latch_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      mode_q   <= MODE_WFI;
      wake_o   <= 1'b0;
      cause_q  <= CAUSE_NONE;
    end else begin
      asleep_q <= asleep_d;
      mode_q   <= mode_d;
      wake_o   <= wake_d;
      cause_q  <= wake_d ? cause_d : CAUSE_NONE;
    end
  end

  lps_pclk_reg #(.N_PCLK(N_PCLK), .PCLK_RST(PCLK_RST)) u_pclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (pclk_wr_i),
    .wdata_i(pclk_wdata_i),
    .en_o   (pclk_en_o)
  );

  assign asleep_o      = asleep_q;
  assign core_clk_en_o = ~asleep_q;
  assign wake_cause_o  = cause_q;

  // entry only follows a request
  assert_entry_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep_o) |-> $past(wfi_i | wfe_i | (isr_ret_i & sleep_on_exit_i)));

  // handler return without the sleep-on-exit bit never sleeps (R3)
  assert_isr_ret_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && isr_ret_i && !sleep_on_exit_i && !wfi_i && !wfe_i) |=> !asleep_o);

  assert_wfi_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && mode_q == MODE_WFI && |(irq_pend_i & irq_en_i)) |=> (!asleep_o && wake_o));

  assert_wfi_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && mode_q == MODE_WFI && !(|(irq_pend_i & irq_en_i))) |=> asleep_o);

  assert_wfe_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_o && mode_q == MODE_WFE && |evt_line_i) |=> !asleep_o);

  assert_wake_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  assert_cause_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_o |-> wake_cause_o == 2'd0);

  assert_latch_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && wfe_i && !wfi_i && !(isr_ret_i && sleep_on_exit_i) && latch_q)
      |=> (!asleep_o && !latch_q));

  assert_same_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!asleep_o && wfi_i && |(irq_pend_i & irq_en_i)) |=> !asleep_o);

  assert_pclk_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pclk_wr_i |=> pclk_en_o == $past(pclk_en_o));
endmodule

// File: tb/tb_lps_sleep_ctrl.sv
module tb_lps_sleep_ctrl;
  localparam int N_IRQ = 8;
  localparam int N_EVT = 4;
  localparam int N_PCLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wfi = 0, wfe = 0, isr_ret = 0, soe = 0, sev = 0, pwr = 0;
  logic [N_IRQ-1:0] pend = '0, en = '0;
  logic [N_EVT-1:0] evt = '0;
  logic [N_PCLK-1:0] pdata = '0;
  logic asleep, clk_en, wake;
  logic [N_PCLK-1:0] pclk;
  logic [1:0] cause;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state
  bit m_asleep, m_mode_wfe, m_latch, m_wake;
  int m_cause;
  logic [N_PCLK-1:0] m_pclk;

  always #4 clk = ~clk;

  lps_sleep_ctrl #(.N_IRQ(N_IRQ), .N_EVT(N_EVT), .N_PCLK(N_PCLK), .PCLK_RST(8'h03)) dut (
    .clk(clk), .rst_n(rst_n), .wfi_i(wfi), .wfe_i(wfe), .isr_ret_i(isr_ret),
    .sleep_on_exit_i(soe), .sev_on_pend_i(sev), .irq_pend_i(pend), .irq_en_i(en),
    .evt_line_i(evt), .pclk_wr_i(pwr), .pclk_wdata_i(pdata), .asleep_o(asleep),
    .core_clk_en_o(clk_en), .pclk_en_o(pclk), .wake_o(wake), .wake_cause_o(cause)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_asleep = 0; m_mode_wfe = 0; m_latch = 0; m_wake = 0; m_cause = 0; m_pclk = 8'h03;
    end else begin
      bit irq, ext, pnd, ev, w;
      irq = |(pend & en);
      ext = |evt;
      pnd = sev && |(pend & ~en);
      ev = ext || pnd;
      m_wake = 0;
      m_cause = 0;
      if (!m_asleep) begin
        if (wfi || (isr_ret && soe)) begin
          if (!irq) begin m_asleep = 1; m_mode_wfe = 0; end
          if (ev) m_latch = 1;
        end else if (wfe) begin
          if (m_latch || ev || irq) m_latch = 0;
          else begin m_asleep = 1; m_mode_wfe = 1; end
        end else if (ev) m_latch = 1;
      end else begin
        w = m_mode_wfe ? (irq || ev) : irq;
        if (w) begin
          m_asleep = 0; m_wake = 1;
          m_cause = irq ? 1 : (ext ? 2 : 3);
        end
        if (m_mode_wfe && w) m_latch = 0;
        else if (ev) m_latch = 1;
      end
      if (pwr) m_pclk = pdata;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      chk(asleep == m_asleep, "R2 asleep_o", asleep, m_asleep);
      chk(clk_en == !m_asleep, "R6 core_clk_en_o", clk_en, !m_asleep);
      chk(wake == m_wake, "R6 wake_o", wake, m_wake);
      chk(cause == m_cause, "R6 wake_cause_o", cause, m_cause);
      chk(pclk == m_pclk, "R9 pclk_en_o", pclk, m_pclk);
    end
  end

  task automatic nx();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    chk(0, "watchdog", cycles, 0);
    finish_run();
  end

  initial begin
    repeat (3) nx();
    rst_n = 1;
    nx();
    chk(asleep == 0 && clk_en == 1 && wake == 0 && cause == 0, "R1 reset outputs", asleep, 0);
    chk(pclk == 8'h03, "R1 reset pclk", pclk, 3);

    // WFI entry, non-qualifying stimuli, then interrupt wake
    wfi = 1; nx(); wfi = 0;
    chk(asleep == 1 && clk_en == 0, "R2 wfi entry", asleep, 1);
    evt = 4'h1; nx(); evt = 0;
    chk(asleep == 1, "R4 ext event ignored in wfi sleep", asleep, 1);
    sev = 1; pend = 8'h04; nx(); pend = 0;
    chk(asleep == 1, "R4 masked pending ignored in wfi sleep", asleep, 1);
    sev = 0; pend = 8'h01; en = 8'h01; nx(); pend = 0; en = 0;
    chk(asleep == 0 && wake == 1 && cause == 1 && clk_en == 1, "R6 irq wake", cause, 1);
    nx();
    chk(wake == 0 && cause == 0, "R6 single pulse", wake, 0);

    // latch was set by the event during wfi sleep
    wfe = 1; nx(); wfe = 0;
    chk(asleep == 0, "R7 wfe returns on latch", asleep, 0);
    wfe = 1; nx(); wfe = 0;
    chk(asleep == 1, "R7 second wfe sleeps", asleep, 1);

    // masked pending with and without send-event bit
    pend = 8'h04; nx();
    chk(asleep == 1, "R5 masked pending without sev", asleep, 1);
    sev = 1; nx(); pend = 0; sev = 0;
    chk(asleep == 0 && cause == 3, "R5 masked pending with sev", cause, 3);

    // external event wake
    wfe = 1; nx(); wfe = 0;
    chk(asleep == 1, "R5 wfe entry", asleep, 1);
    evt = 4'h2; nx(); evt = 0;
    chk(asleep == 0 && cause == 2, "R5 ext event wake", cause, 2);

    // handler return under sleep-on-exit
    isr_ret = 1; nx(); isr_ret = 0;
    chk(asleep == 0, "R3 return ignored without soe", asleep, 0);
    soe = 1; isr_ret = 1; nx(); isr_ret = 0;
    chk(asleep == 1, "R3 return enters sleep", asleep, 1);
    evt = 4'h8; nx(); evt = 0;
    chk(asleep == 1, "R3 wfi-type rules after return", asleep, 1);
    pend = 8'h80; en = 8'h80; nx(); pend = 0; en = 0; soe = 0;
    chk(asleep == 0 && cause == 1, "R3 irq wakes after return", cause, 1);
    wfe = 1; nx(); wfe = 0;
    chk(asleep == 0, "R7 latch consumed", asleep, 0);

    // same-cycle wake conditions
    wfi = 1; pend = 8'h02; en = 8'h02; nx(); wfi = 0; pend = 0; en = 0;
    chk(asleep == 0 && wake == 0, "R8 wfi with accepted irq stays awake", asleep, 0);
    wfe = 1; evt = 4'h1; nx(); wfe = 0; evt = 0;
    chk(asleep == 0, "R8 wfe with event stays awake", asleep, 0);
    wfe = 1; nx(); wfe = 0;
    chk(asleep == 1, "R8 consumed event did not latch", asleep, 1);
    evt = 4'h1; nx(); evt = 0;
    chk(asleep == 0 && cause == 2, "R8 wake after", cause, 2);

    // both strobes together
    wfi = 1; wfe = 1; nx(); wfi = 0; wfe = 0;
    chk(asleep == 1, "R10 dual strobe sleeps", asleep, 1);
    evt = 4'h4; nx(); evt = 0;
    chk(asleep == 1, "R10 wfi rules applied", asleep, 1);
    pend = 8'h10; en = 8'h10; nx(); pend = 0; en = 0;
    chk(asleep == 0, "R10 irq wake", asleep, 0);
    wfe = 1; nx(); wfe = 0;

    // peripheral enables across sleep
    pwr = 1; pdata = 8'hA5; nx(); pwr = 0; pdata = 0;
    chk(pclk == 8'hA5, "R9 write", pclk, 8'hA5);
    wfi = 1; nx(); wfi = 0;
    chk(asleep == 1 && pclk == 8'hA5, "R9 hold on entry", pclk, 8'hA5);
    pend = 8'h01; en = 8'h01; nx(); pend = 0; en = 0;
    chk(pclk == 8'hA5, "R9 hold on wake", pclk, 8'hA5);

    // cause priority
    wfe = 1; nx(); wfe = 0;
    evt = 4'h1; pend = 8'h01; en = 8'h01; sev = 1; nx(); evt = 0; pend = 0; en = 0; sev = 0;
    chk(cause == 1, "R6 irq has priority", cause, 1);
    wfe = 1; nx(); wfe = 0;
    evt = 4'h1; pend = 8'h08; sev = 1; nx(); evt = 0; pend = 0; sev = 0;
    chk(cause == 2, "R6 ext over masked pending", cause, 2);

    repeat (3) nx();
    finish_run();
  end
endmodule